// File: doc/BRIEF.md
# SCSI Bus Arbitration Controller

This block runs the arbitration step of a SCSI device that holds a 3-bit bus ID. The host starts it by raising an arbitrate bit in its mode setting. If the bus is not already in selection by someone else, the block asserts BSY and drives the host-supplied output byte onto the data lines. It then waits a fixed arbitration delay, samples the data lines, and finds the highest-numbered set bit. The block has won only when that bit index equals its own ID.

After a loss, the block lets go of every line it drives. After a win, it keeps BSY and the data byte asserted so that later logic can go on to selection. Two host-visible flags report progress. The in-progress flag is sticky: it stays set after the outcome is known, whether the block won or lost, and it clears only when the host drops the arbitrate bit. The lost flag reports a start that was refused because SEL was already asserted. The host can also drive BSY, SEL and the data bus directly through command bits.

Top module: `scsi_arb_top`

## Requirements
- R1: After reset, busDataOe, bsyOut, selOut, arbInProg, arbLost and arbWon are all 0, and busDataOut is 0.
- R2: A 0-to-1 change of modeArb, when SEL is free or cmdAssertSel is 1, takes effect at the next clock edge. From that edge arbInProg is 1, arbLost is 0, bsyOut is 1, busDataOe is 1 and busDataOut equals outData.
- R3: A 0-to-1 change of modeArb while busSelIn is 1 and cmdAssertSel is 0 refuses the start. At the next edge arbLost becomes 1, arbInProg keeps its value, and no line is driven by arbitration.
- R4: When busSelIn is 1 and cmdAssertSel is 1, arbitration starts exactly as in R2.
- R5: The outcome is decided at the ARB_DELAY-th clock edge after the start edge; before then arbWon is 0. The winner is the index of the highest set bit of busDataIn (bit 7 is highest). arbWon becomes 1 only if that index equals ownId. While arbWon is 1, bsyOut and busDataOe stay 1.
- R6: On a loss, bsyOut, selOut and busDataOe all drop to 0, even when command bits request them. This lasts until modeArb returns to 0.
- R7: arbInProg stays 1 after a win or a loss. It clears only at the edge after modeArb goes from 1 to 0. That same edge ends arbitration and releases the BSY and data drive that arbitration held.
- R8: Outside a loss, cmdAssertBsy drives bsyOut and cmdAssertSel drives selOut. cmdAssertDbus drives busDataOe with busDataOut equal to outData. These lines follow the bits within the same cycle.
- R9: softRst at a clock edge cancels any arbitration and clears arbInProg and arbLost. Lines that arbitration held are released.
- R10: If busDataIn is 0 when the outcome is decided, the block has lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous soft reset of arbitration state |
| ownId | input | 3 | This device's bus ID |
| modeArb | input | 1 | Arbitrate bit from the mode setting |
| cmdAssertSel | input | 1 | Host command: assert SEL |
| cmdAssertBsy | input | 1 | Host command: assert BSY |
| cmdAssertDbus | input | 1 | Host command: drive the data bus |
| outData | input | 8 | Byte the block drives onto the data bus |
| busDataIn | input | 8 | Sampled SCSI data lines, 1 = asserted |
| busSelIn | input | 1 | Sampled SEL line, 1 = asserted |
| busDataOut | output | 8 | Data byte driven to the bus |
| busDataOe | output | 1 | Data bus drive enable |
| bsyOut | output | 1 | BSY drive |
| selOut | output | 1 | SEL drive |
| arbInProg | output | 1 | Sticky arbitration-in-progress flag |
| arbLost | output | 1 | Refused-start (lost) flag |
| arbWon | output | 1 | Arbitration decided in this device's favour |

## Verification
The bench builds the block with ARB_DELAY set to 6 instead of the 240-cycle default. Each arbitration then resolves in a few cycles, so one run holds many random trials, each with its own ID, bus byte and SEL state. It also covers the directed cases: the refused start, the empty bus, a soft reset in mid-arbitration, and the cycle just before the decision edge. The count window is a parameter, so the decision-cycle checks measure the same boundary at any delay.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_WON,
    ST_LOST
  } arbState_e;

  typedef struct packed {
    logic startArb;
    logic failStart;
    logic clrInProg;
    logic cancel;
  } arbStrobe_t;

endpackage

// File: rtl/scsi_arb_ctrl.sv
module scsi_arb_ctrl
  import scsi_arb_pkg::*;
#(
  parameter int ARB_DELAY = 240
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       modeArb,
  input  logic       busSelIn,
  input  logic       cmdAssertSel,
  input  logic       idMatch,
  output arbStrobe_t strb,
  output arbState_e  state
);

  localparam int CNT_W = (ARB_DELAY > 1) ? $clog2(ARB_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ARB_DELAY - 1);

  logic             modeArbQ;
  logic [CNT_W-1:0] cnt;
  arbState_e        stateNxt;
  logic             arbRise;
  logic             arbFall;
  logic             cntDone;

  assign arbRise = modeArb & ~modeArbQ;
  assign arbFall = ~modeArb & modeArbQ;
  assign cntDone = (cnt == '0);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    if (softRst) begin
      strb.cancel = 1'b1;
      stateNxt    = ST_IDLE;
    end else if (arbFall) begin
      strb.clrInProg = 1'b1;
      stateNxt       = ST_IDLE;
    end else if (arbRise) begin
      if (busSelIn && !cmdAssertSel) begin
        strb.failStart = 1'b1;
      end else begin
        strb.startArb = 1'b1;
        stateNxt      = ST_ARB;
      end
    end else if (state == ST_ARB && cntDone) begin
      stateNxt = idMatch ? ST_WON : ST_LOST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeArbQ <= 1'b0;
      cnt      <= '0;
    end else begin
      state    <= stateNxt;
      modeArbQ <= modeArb;
      if (strb.startArb) begin
        cnt <= CNT_LOAD;
      end else if (state == ST_ARB && !cntDone) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/scsi_arb_datapath.sv
module scsi_arb_datapath
  import scsi_arb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strb,
  input  arbState_e         state,
  input  logic [ID_W-1:0]   ownId,
  input  logic              cmdAssertSel,
  input  logic              cmdAssertBsy,
  input  logic              cmdAssertDbus,
  input  logic [DATA_W-1:0] outData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              idMatch,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              bsyOut,
  output logic              selOut,
  output logic              arbInProg,
  output logic              arbLost
);

  logic [ID_W-1:0] topIdx;
  logic            topValid;
  logic            arbHold;
  logic            quiet;

  // highest set bit wins; later (higher) iterations override
  always_comb begin
    topIdx   = '0;
    topValid = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (busDataIn[i]) begin
        topIdx   = ID_W'(i);
        topValid = 1'b1;
      end
    end
  end

  assign idMatch = topValid && (topIdx == ownId);

  assign arbHold = (state == ST_ARB) || (state == ST_WON);
  assign quiet   = (state == ST_LOST);

  assign bsyOut     = !quiet && (arbHold || cmdAssertBsy);
  assign selOut     = !quiet && cmdAssertSel;
  assign busDataOe  = !quiet && (arbHold || cmdAssertDbus);
  assign busDataOut = busDataOe ? outData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arbInProg <= 1'b0;
      arbLost   <= 1'b0;
    end else if (strb.cancel) begin
      arbInProg <= 1'b0;
      arbLost   <= 1'b0;
    end else begin
      if (strb.clrInProg) arbInProg <= 1'b0;
      if (strb.failStart) arbLost   <= 1'b1;
      if (strb.startArb) begin
        arbInProg <= 1'b1;
        arbLost   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/scsi_arb_top.sv
module scsi_arb_top
  import scsi_arb_pkg::*;
#(
  parameter int ARB_DELAY = 240
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic [2:0] ownId,
  input  logic       modeArb,
  input  logic       cmdAssertSel,
  input  logic       cmdAssertBsy,
  input  logic       cmdAssertDbus,
  input  logic [7:0] outData,
  input  logic [7:0] busDataIn,
  input  logic       busSelIn,
  output logic [7:0] busDataOut,
  output logic       busDataOe,
  output logic       bsyOut,
  output logic       selOut,
  output logic       arbInProg,
  output logic       arbLost,
  output logic       arbWon
);

  arbStrobe_t strb;
  arbState_e  state;
  logic       idMatch;

  scsi_arb_ctrl #(.ARB_DELAY(ARB_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .modeArb(modeArb),
    .busSelIn(busSelIn), .cmdAssertSel(cmdAssertSel), .idMatch(idMatch),
    .strb(strb), .state(state)
  );

  scsi_arb_datapath #(.DATA_W(8), .ID_W(3)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .state(state), .ownId(ownId),
    .cmdAssertSel(cmdAssertSel), .cmdAssertBsy(cmdAssertBsy),
    .cmdAssertDbus(cmdAssertDbus), .outData(outData), .busDataIn(busDataIn),
    .idMatch(idMatch), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .bsyOut(bsyOut), .selOut(selOut), .arbInProg(arbInProg), .arbLost(arbLost)
  );

  assign arbWon = (state == ST_WON);

endmodule

// File: rtl/scsi_arb_chk.sv
module scsi_arb_chk (
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic [2:0] ownId,
  input logic       modeArb,
  input logic       cmdAssertSel,
  input logic       cmdAssertBsy,
  input logic       cmdAssertDbus,
  input logic [7:0] outData,
  input logic [7:0] busDataIn,
  input logic       busSelIn,
  input logic [7:0] busDataOut,
  input logic       busDataOe,
  input logic       bsyOut,
  input logic       selOut,
  input logic       arbInProg,
  input logic       arbLost,
  input logic       arbWon
);

  logic modeArbSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeArbSeen <= 1'b0;
    else       modeArbSeen <= modeArb;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && modeArb && !modeArbSeen && !(busSelIn && !cmdAssertSel))
      |=> (arbInProg && !arbLost && bsyOut && busDataOe));

  p_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && modeArb && !modeArbSeen && busSelIn && !cmdAssertSel)
      |=> arbLost);

  p_won_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    arbWon |-> (bsyOut && busDataOe));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (arbInProg && modeArb && !softRst) |=> arbInProg);

  p_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeArbSeen && !modeArb) |=> !arbInProg);

  p_soft_r9: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!arbInProg && !arbLost && !arbWon));

  p_oe_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (busDataOut == outData));

endmodule

bind scsi_arb_top scsi_arb_chk chk_i (.*);

// File: tb/scsi_arb_tb.sv
module scsi_arb_top_tb_top;

  localparam int D = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic [2:0] ownId = '0;
  logic       modeArb = 1'b0;
  logic       cmdAssertSel = 1'b0;
  logic       cmdAssertBsy = 1'b0;
  logic       cmdAssertDbus = 1'b0;
  logic [7:0] outData = '0;
  logic [7:0] busDataIn = '0;
  logic       busSelIn = 1'b0;
  logic [7:0] busDataOut;
  logic       busDataOe, bsyOut, selOut, arbInProg, arbLost, arbWon;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  scsi_arb_top #(.ARB_DELAY(D)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit expWin(logic [7:0] bus, logic [2:0] id);
    int top = -1;
    for (int i = 0; i < 8; i++) if (bus[i]) top = i;
    return (top == int'(id));
  endfunction

  // one full arbitration, all command bits except SEL cleared
  task automatic runArb(logic [2:0] id, logic [7:0] bus, logic cs, logic bs);
    bit blocked, win;
    @(negedge clk);
    ownId = id; busDataIn = bus; cmdAssertSel = cs; busSelIn = bs;
    cmdAssertBsy = 0; cmdAssertDbus = 0;
    outData = 8'(1 << id);
    modeArb = 1;
    blocked = bs && !cs;
    @(negedge clk);
    if (blocked) begin
      chk("R3 lost", arbLost, 1);
      chk("R3 inprog", arbInProg, 0);
      chk("R3 bsy", bsyOut, 0);
      chk("R3 oe", busDataOe, 0);
    end else begin
      chk(bs ? "R4 inprog" : "R2 inprog", arbInProg, 1);
      chk("R2 lost", arbLost, 0);
      chk("R2 bsy", bsyOut, 1);
      chk("R2 oe", busDataOe, 1);
      chk("R2 data", busDataOut, outData);
      repeat (D - 1) @(negedge clk);
      chk("R5 early", arbWon, 0);
      @(negedge clk);
      win = expWin(bus, id);
      chk(bus == 0 ? "R10 won" : "R5 won", arbWon, win);
      chk("R5 bsy", bsyOut, win);
      chk("R6 oe", busDataOe, win);
      chk("R6 sel", selOut, win ? cs : 1'b0);
      chk("R7 sticky", arbInProg, 1);
    end
    modeArb = 0;
    @(negedge clk);
    chk("R7 fall", arbInProg, 0);
    chk("R7 bsy", bsyOut, 0);
    chk("R7 won", arbWon, 0);
    cmdAssertSel = 0; busSelIn = 0;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChk - nFail + 1, nChk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5c51));
    repeat (3) @(negedge clk);
    chk("R1 oe", busDataOe, 0);
    chk("R1 bsy", bsyOut, 0);
    chk("R1 flags", {arbInProg, arbLost, arbWon, selOut}, 0);
    chk("R1 data", busDataOut, 0);
    rstN = 1;
    @(negedge clk);

    // R8 command bits
    cmdAssertBsy = 1; cmdAssertSel = 1; cmdAssertDbus = 1; outData = 8'hA5;
    #1;
    chk("R8 bsy", bsyOut, 1);
    chk("R8 sel", selOut, 1);
    chk("R8 data", {busDataOe, busDataOut}, {1'b1, 8'hA5});
    @(negedge clk);
    cmdAssertBsy = 0; cmdAssertSel = 0; cmdAssertDbus = 0;
    #1;
    chk("R8 release", {bsyOut, selOut, busDataOe}, 0);

    // directed corner cases
    runArb(3'd7, 8'h80, 0, 0);          // top ID wins
    runArb(3'd2, 8'h24, 0, 0);          // higher ID present: loss
    runArb(3'd0, 8'h00, 0, 0);          // R10 empty bus
    runArb(3'd4, 8'h10, 0, 1);          // R3 refused start
    chk("R3 lost persists", arbLost, 1);
    runArb(3'd5, 8'h21, 1, 1);          // R4 own SEL allows start
    chk("R2 lost cleared", arbLost, 0);

    // R6 loss overrides command bits
    @(negedge clk);
    ownId = 1; busDataIn = 8'h40; modeArb = 1;
    repeat (D + 1) @(negedge clk);
    cmdAssertBsy = 1; cmdAssertDbus = 1;
    #1;
    chk("R6 quiet bsy", bsyOut, 0);
    chk("R6 quiet oe", busDataOe, 0);
    @(negedge clk);
    cmdAssertBsy = 0; cmdAssertDbus = 0; modeArb = 0;
    @(negedge clk);

    // R9 soft reset mid-arbitration
    ownId = 6; busDataIn = 8'h40; modeArb = 1;
    repeat (2) @(negedge clk);
    softRst = 1;
    @(negedge clk);
    softRst = 0;
    chk("R9 inprog", arbInProg, 0);
    chk("R9 bsy", bsyOut, 0);
    repeat (D + 1) @(negedge clk);
    chk("R9 no win", arbWon, 0);
    modeArb = 0;
    @(negedge clk);

    // random trials
    for (int t = 0; t < 60; t++) begin
      logic [2:0] id;
      logic [7:0] bus;
      id  = 3'($urandom_range(0, 7));
      bus = 8'($urandom);
      if ($urandom_range(0, 3) == 0) bus = bus & 8'((1 << (id + 1)) - 1) | 8'(1 << id);
      runArb(id, bus, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule